// File: doc/BRIEF.md
# Threshold DMA-Request Endpoint FIFO

This block is a four-entry, halfword-wide buffer between a USB endpoint and local logic. A direction input selects which way data moves. Toward local logic, the endpoint side supplies bytes. A holding register pairs these bytes into halfwords, low byte first, and the local side removes whole halfwords. Away from local logic, the local side pushes halfwords and the endpoint side takes them out one byte at a time, low byte first.

The number of occupied entries is compared against a programmable threshold. When the level reaches the threshold, a DMA request is raised to an external DMA controller. A blocking input can mask that request while the unmasked condition stays visible in status. When the enable input is dropped in the middle of a DMA transfer, the enabled state is kept until the transfer ends. The buffer is then flushed.

A 16-bit status word reports the enable, request, ready, threshold, pointer, fill and holding-register state.

Top module: `thr_ep_fifo`

## Requirements
- R1: After reset, `status_o` reads 0 and `dma_req_o` is low. The status layout is: bit 15 enabled; bit 14 raw request; bit 13 ready; bits 12:10 threshold; bits 9:8 read pointer; bit 7 reads 0; bit 6 holding word complete; bit 5 single byte held; bits 4:2 entry count; bits 1:0 write pointer.
- R2: The enabled bit follows `en_i` one clock later. If `en_i` is low while `dma_busy_i` is high, a set enabled bit stays set. It clears on the first clock where both inputs are low.
- R3: On any clock where the enabled state goes to 0, the entry count, both pointers and both holding flags become 0. Queued data is discarded. While the enabled state is held by `dma_busy_i`, nothing is cleared.
- R4: The entry count runs from 0 to 4. A push and a pop in the same cycle leave it unchanged. A push when it is 4 has no effect, and a pop when it is 0 has no effect.
- R5: When `dir_i`=1 (toward local), the halfwords read on `hw_rdata_o` come out in arrival order. Each one is {second byte, first byte} of the bytes written on `byte_wdata_i`.
- R6: When `dir_i`=0 (from local), each halfword written on `hw_wdata_i` is read as two bytes on `byte_rdata_o`, bits 7:0 first. The entry is removed only when its upper byte is read.
- R7: When `dir_i`=1, the first byte of a pair sets bit 5. The second byte clears bit 5 and sets bit 6. A completed word moves into the FIFO on the next clock in which the FIFO is not full, and this clears bit 6. Bytes written while bit 6 is set are dropped.
- R8: The effective threshold is the 3-bit threshold field, limited to a maximum of 4. The raw request bit is 1 when the effective threshold is nonzero and the entry count is at least the effective threshold. A threshold of 0 never requests.
- R9: `dma_req_o` equals the raw request bit with `blk_i` low, and it is 0 whenever `blk_i` is high. The raw request bit ignores `blk_i`.
- R10: The ready bit is 0 when the block is disabled. When enabled, it is 0 if the buffer is empty with `dir_i`=1, or full with `dir_i`=0, and 1 otherwise.
- R11: Each write pointer and read pointer advances by one, modulo 4, on every accepted push and pop respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Local enable |
| dir_i | input | 1 | 1: data toward local logic, 0: data from local logic |
| dma_busy_i | input | 1 | A DMA transfer is in progress |
| blk_i | input | 1 | Terminal-count / request blocking |
| ctl_we_i | input | 1 | Load the threshold field |
| ctl_thr_i | input | 3 | New threshold value |
| byte_wr_i | input | 1 | Endpoint byte write strobe |
| byte_wdata_i | input | 8 | Endpoint byte write data |
| byte_rd_i | input | 1 | Endpoint byte read strobe |
| byte_rdata_o | output | 8 | Endpoint byte read data |
| hw_wr_i | input | 1 | Local halfword push strobe |
| hw_wdata_i | input | 16 | Local halfword push data |
| hw_rd_i | input | 1 | Local halfword pop strobe |
| hw_rdata_o | output | 16 | Head halfword |
| dma_req_o | output | 1 | Blockable DMA request |
| status_o | output | 16 | Status and control word |

## Verification
A miscounted fill level shows up in the cycle after the faulty push or pop. It is visible in bits 4:2, and it moves the request edge to the wrong entry for some threshold. Sweeping every threshold value therefore exposes it within four operations. A wrong pointer or holding-register step leaves the fill level correct but corrupts data order. The scoreboard then sees a wrong byte or halfword on the very next read. A faulty enable-hold path shows as early or late clearing of bit 15 and the count, in the one clock after `en_i` or `dma_busy_i` changes.

// File: rtl/tef_pkg.sv
package tef_pkg;
  localparam int unsigned EF_DEPTH = 4;
  localparam int unsigned EF_BW    = 8;
  localparam int unsigned EF_THR_W = 3;
  localparam int unsigned EF_DW    = 2 * EF_BW;
  localparam int unsigned EF_PTR_W = $clog2(EF_DEPTH);
  localparam int unsigned EF_QTY_W = $clog2(EF_DEPTH + 1);
  localparam int unsigned EF_CMP_W = (EF_QTY_W > EF_THR_W) ? EF_QTY_W : EF_THR_W;

  typedef logic [EF_BW-1:0]    byte_t;
  typedef logic [EF_DW-1:0]    hw_t;
  typedef logic [EF_PTR_W-1:0] ptr_t;
  typedef logic [EF_QTY_W-1:0] qty_t;
  typedef logic [EF_THR_W-1:0] thr_t;

  typedef enum logic {DIR_FROM_LOCAL = 1'b0, DIR_TO_LOCAL = 1'b1} dir_e;

  typedef struct packed {
    logic enabled;
    logic data_req;
    logic ready;
    thr_t thr;
    ptr_t optr;
    logic rsvd;
    logic hold_full;
    logic byte_held;
    qty_t qty;
    ptr_t iptr;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);
endpackage

// File: rtl/tef_ctrl.sv
module tef_ctrl
  import tef_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dma_busy_i,
  input  logic ctl_we_i,
  input  thr_t ctl_thr_i,
  input  qty_t qty_i,
  input  logic blk_i,
  output logic en_q_o,
  output logic en_nx_o,
  output thr_t thr_o,
  output logic raw_req_o,
  output logic dma_req_o
);
  localparam thr_t THR_CAP = thr_t'(EF_DEPTH);

  logic en_q, en_d;
  thr_t thr_q, thr_d, thr_eff;
  logic [EF_CMP_W-1:0] lvl, lim;

  // enable holds while a transfer is running
  always_comb begin
    en_d  = en_i | (en_q & dma_busy_i);
    thr_d = thr_q;
    if (ctl_we_i) thr_d = ctl_thr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      en_q  <= en_d;
      thr_q <= thr_d;
    end
  end

  always_comb begin
    thr_eff = (thr_q > THR_CAP) ? THR_CAP : thr_q;
    lvl     = EF_CMP_W'(qty_i);
    lim     = EF_CMP_W'(thr_eff);
  end

  assign raw_req_o = en_q & (thr_eff != '0) & (lvl >= lim);
  assign dma_req_o = raw_req_o & ~blk_i;
  assign en_q_o    = en_q;
  assign en_nx_o   = en_d;
  assign thr_o     = thr_q;
endmodule

// File: rtl/tef_pack.sv
module tef_pack
  import tef_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_i,
  input  logic  act_i,
  input  logic  byte_wr_i,
  input  byte_t byte_i,
  input  logic  take_i,
  output hw_t   hold_o,
  output logic  full_o,
  output logic  byte_o
);
  byte_t lo_q, lo_d, hi_q, hi_d;
  logic  full_q, full_d, one_q, one_d;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    full_d = full_q;
    one_d  = one_q;
    if (clr_i) begin
      full_d = 1'b0;
      one_d  = 1'b0;
    end else if (act_i) begin
      if (take_i) full_d = 1'b0;
      if (byte_wr_i && !full_q) begin
        if (!one_q) begin
          lo_d  = byte_i;
          one_d = 1'b1;
        end else begin
          hi_d   = byte_i;
          one_d  = 1'b0;
          full_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      full_q <= 1'b0;
      one_q  <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      full_q <= full_d;
      one_q  <= one_d;
    end
  end

  assign hold_o = {hi_q, lo_q};
  assign full_o = full_q;
  assign byte_o = one_q;
endmodule

// File: rtl/tef_store.sv
module tef_store
  import tef_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic push_i,
  input  logic pop_i,
  input  hw_t  wdata_i,
  output hw_t  head_o,
  output ptr_t iptr_o,
  output ptr_t optr_o,
  output qty_t qty_o,
  output logic full_o,
  output logic empty_o
);
  localparam qty_t QTY_FULL = qty_t'(EF_DEPTH);
  localparam ptr_t PTR_LAST = ptr_t'(EF_DEPTH - 1);

  hw_t  mem [EF_DEPTH];
  ptr_t iptr_q, iptr_d, optr_q, optr_d;
  qty_t qty_q, qty_d;

  function automatic ptr_t bump(input ptr_t p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    iptr_d = iptr_q;
    optr_d = optr_q;
    qty_d  = qty_q;
    if (clr_i) begin
      iptr_d = '0;
      optr_d = '0;
      qty_d  = '0;
    end else begin
      if (push_i) iptr_d = bump(iptr_q);
      if (pop_i)  optr_d = bump(optr_q);
      case ({push_i, pop_i})
        2'b10:   qty_d = qty_q + 1'b1;
        2'b01:   qty_d = qty_q - 1'b1;
        default: qty_d = qty_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iptr_q <= '0;
      optr_q <= '0;
      qty_q  <= '0;
    end else begin
      iptr_q <= iptr_d;
      optr_q <= optr_d;
      qty_q  <= qty_d;
    end
  end

  // data storage carries no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < EF_DEPTH; i++) begin
      if (push_i && !clr_i && (iptr_q == ptr_t'(i))) mem[i] <= wdata_i;
    end
  end

  assign head_o  = mem[optr_q];
  assign iptr_o  = iptr_q;
  assign optr_o  = optr_q;
  assign qty_o   = qty_q;
  assign full_o  = (qty_q == QTY_FULL);
  assign empty_o = (qty_q == '0);
endmodule

// File: rtl/thr_ep_fifo.sv
module thr_ep_fifo
  import tef_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              dir_i,
  input  logic              dma_busy_i,
  input  logic              blk_i,
  input  logic              ctl_we_i,
  input  logic [EF_THR_W-1:0] ctl_thr_i,
  input  logic              byte_wr_i,
  input  logic [EF_BW-1:0]  byte_wdata_i,
  input  logic              byte_rd_i,
  output logic [EF_BW-1:0]  byte_rdata_o,
  input  logic              hw_wr_i,
  input  logic [EF_DW-1:0]  hw_wdata_i,
  input  logic              hw_rd_i,
  output logic [EF_DW-1:0]  hw_rdata_o,
  output logic              dma_req_o,
  output logic [STAT_W-1:0] status_o
);
  logic en_q, en_nx, clr, op, to_local, raw_req;
  logic push, pop, pop_hw, brd_ok, take;
  logic hold_full, byte_held, full, empty;
  logic rd_half_q, rd_half_d;
  thr_t thr;
  ptr_t iptr, optr;
  qty_t qty;
  hw_t  hold, head, wdata;
  stat_t st;

  assign to_local = (dir_e'(dir_i) == DIR_TO_LOCAL);
  assign clr      = ~en_nx;
  assign op       = en_q & en_nx;

  assign push   = op & ~full & (to_local ? hold_full : hw_wr_i);
  assign pop_hw = op & to_local & hw_rd_i & ~empty;
  assign brd_ok = op & ~to_local & byte_rd_i & ~empty;
  assign pop    = pop_hw | (brd_ok & rd_half_q);
  assign take   = push & to_local;
  assign wdata  = to_local ? hold : hw_wdata_i;

  tef_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .dma_busy_i(dma_busy_i),
    .ctl_we_i(ctl_we_i), .ctl_thr_i(ctl_thr_i), .qty_i(qty), .blk_i(blk_i),
    .en_q_o(en_q), .en_nx_o(en_nx), .thr_o(thr), .raw_req_o(raw_req),
    .dma_req_o(dma_req_o)
  );

  tef_pack pack_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .act_i(op & to_local),
    .byte_wr_i(byte_wr_i), .byte_i(byte_wdata_i), .take_i(take),
    .hold_o(hold), .full_o(hold_full), .byte_o(byte_held)
  );

  tef_store store_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .push_i(push), .pop_i(pop),
    .wdata_i(wdata), .head_o(head), .iptr_o(iptr), .optr_o(optr),
    .qty_o(qty), .full_o(full), .empty_o(empty)
  );

  // byte-lane select for endpoint reads, low lane first
  always_comb begin
    rd_half_d = rd_half_q;
    if (clr)         rd_half_d = 1'b0;
    else if (brd_ok) rd_half_d = ~rd_half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_half_q <= 1'b0;
    else        rd_half_q <= rd_half_d;
  end

  assign byte_rdata_o = rd_half_q ? head[EF_DW-1:EF_BW] : head[EF_BW-1:0];
  assign hw_rdata_o   = head;

  always_comb begin
    st.enabled   = en_q;
    st.data_req  = raw_req;
    st.ready     = en_q & (to_local ? ~empty : ~full);
    st.thr       = thr;
    st.optr      = optr;
    st.rsvd      = 1'b0;
    st.hold_full = hold_full;
    st.byte_held = byte_held;
    st.qty       = qty;
    st.iptr      = iptr;
  end

  assign status_o = st;
endmodule

// File: rtl/thr_ep_fifo_chk.sv
module thr_ep_fifo_chk
  import tef_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              dma_busy_i,
  input logic              blk_i,
  input logic              dma_req_o,
  input logic [STAT_W-1:0] status_o
);
  stat_t s;
  assign s = stat_t'(status_o);

  // R9
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> (s.data_req && !blk_i));

  // R9
  req_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s.data_req && !blk_i) |-> dma_req_o);

  // R4
  qty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s.qty <= qty_t'(EF_DEPTH));

  // R8
  thr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s.thr == '0) |-> !s.data_req);

  // R2
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !dma_busy_i) |=> !s.enabled);

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s.enabled && dma_busy_i) |=> s.enabled);

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !dma_busy_i) |=> (s.qty == '0 && s.iptr == '0 && s.optr == '0
                                && !s.hold_full && !s.byte_held));

  // R7
  hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s.hold_full && s.byte_held));

  // R10
  ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s.enabled |-> !s.ready);
endmodule

bind thr_ep_fifo thr_ep_fifo_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .dma_busy_i(dma_busy_i),
  .blk_i(blk_i), .dma_req_o(dma_req_o), .status_o(status_o)
);

// File: tb/thr_ep_fifo_tb_top.sv
module thr_ep_fifo_tb_top;
  import tef_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic en_i, dir_i, dma_busy_i, blk_i, ctl_we_i;
  logic [EF_THR_W-1:0] ctl_thr_i;
  logic byte_wr_i, byte_rd_i, hw_wr_i, hw_rd_i;
  logic [EF_BW-1:0] byte_wdata_i, byte_rdata_o;
  logic [EF_DW-1:0] hw_wdata_i, hw_rdata_o;
  logic dma_req_o;
  logic [STAT_W-1:0] status_o;
  stat_t st;

  int nchk = 0;
  int nfail = 0;
  byte_t expb[$];
  hw_t   exph[$];

  assign st = stat_t'(status_o);

  always #2 clk = ~clk;

  thr_ep_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .dir_i(dir_i), .dma_busy_i(dma_busy_i),
    .blk_i(blk_i), .ctl_we_i(ctl_we_i), .ctl_thr_i(ctl_thr_i),
    .byte_wr_i(byte_wr_i), .byte_wdata_i(byte_wdata_i), .byte_rd_i(byte_rd_i),
    .byte_rdata_o(byte_rdata_o), .hw_wr_i(hw_wr_i), .hw_wdata_i(hw_wdata_i),
    .hw_rd_i(hw_rd_i), .hw_rdata_o(hw_rdata_o), .dma_req_o(dma_req_o),
    .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic flush();
    en_i = 1'b0;
    tick();
    en_i = 1'b1;
    tick();
    expb.delete();
    exph.delete();
  endtask

  task automatic set_thr(input int t);
    ctl_thr_i = thr_t'(t);
    ctl_we_i  = 1'b1;
    tick();
    ctl_we_i  = 1'b0;
  endtask

  // driver: a push accepted below four entries queues its two bytes
  task automatic push_hw(input hw_t d);
    hw_wr_i    = 1'b1;
    hw_wdata_i = d;
    if (st.enabled && st.qty < 3'd4) begin
      expb.push_back(d[7:0]);
      expb.push_back(d[15:8]);
    end
    tick();
    hw_wr_i = 1'b0;
  endtask

  task automatic pop_byte();
    byte_rd_i = 1'b1;
    tick();
    byte_rd_i = 1'b0;
  endtask

  task automatic pop_hw();
    hw_rd_i = 1'b1;
    tick();
    hw_rd_i = 1'b0;
  endtask

  task automatic wr_byte(input byte_t b);
    byte_wr_i    = 1'b1;
    byte_wdata_i = b;
    tick();
    byte_wr_i = 1'b0;
  endtask

  task automatic write_entry(input hw_t d);
    wr_byte(d[7:0]);
    wr_byte(d[15:8]);
    tick();
    exph.push_back(d);
  endtask

  // monitor: compare data as the design hands it out
  always @(negedge clk) begin
    if (rst_n && st.enabled && st.qty != '0) begin
      if (byte_rd_i && dir_i == 1'b0) begin
        if (expb.size() == 0) chk("R6 unexpected byte read", 32'(byte_rdata_o), 32'hFFFF_FFFF);
        else chk("R6 byte order", 32'(byte_rdata_o), 32'(expb.pop_front()));
      end
      if (hw_rd_i && dir_i == 1'b1) begin
        if (exph.size() == 0) chk("R5 unexpected halfword read", 32'(hw_rdata_o), 32'hFFFF_FFFF);
        else chk("R5 halfword order", 32'(hw_rdata_o), 32'(exph.pop_front()));
      end
    end
  end

  initial begin
    #(4 * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    ptr_t oprev;
    rst_n = 1'b0;
    en_i = 1'b0; dir_i = 1'b0; dma_busy_i = 1'b0; blk_i = 1'b0;
    ctl_we_i = 1'b0; ctl_thr_i = '0;
    byte_wr_i = 1'b0; byte_wdata_i = '0; byte_rd_i = 1'b0;
    hw_wr_i = 1'b0; hw_wdata_i = '0; hw_rd_i = 1'b0;
    tick(); tick();
    chk("R1 reset status", 32'(status_o), 32'h0);
    chk("R1 reset request", 32'(dma_req_o), 32'h0);
    rst_n = 1'b1;
    tick();

    en_i = 1'b1;
    tick();
    chk("R2 enabled follows en_i", 32'(st.enabled), 32'h1);
    chk("R10 ready when empty, from local", 32'(st.ready), 32'h1);

    // threshold sweep with halfword pushes (dir 0)
    for (int t = 0; t < 8; t++) begin
      int eff;
      eff = (t > 4) ? 4 : t;
      flush();
      set_thr(t);
      chk("R8 threshold field", 32'(st.thr), 32'(t));
      for (int k = 1; k <= 4; k++) begin
        push_hw({8'(t), 8'(k)});
        chk("R4 count on push", 32'(st.qty), 32'(k));
        chk("R8 raw request on fill", 32'(st.data_req), 32'((eff != 0) && (k >= eff)));
        chk("R9 dma request on fill", 32'(dma_req_o), 32'((eff != 0) && (k >= eff)));
      end
      for (int k = 3; k >= 0; k--) begin
        pop_byte();
        pop_byte();
        chk("R4 count on drain", 32'(st.qty), 32'(k));
        chk("R8 raw request on drain", 32'(st.data_req), 32'((eff != 0) && (k >= eff)));
      end
      chk("R6 all bytes delivered", 32'(expb.size()), 32'h0);
    end

    // blocking input
    flush();
    set_thr(2);
    push_hw(16'hA1A0);
    push_hw(16'hA2A0);
    blk_i = 1'b1;
    #1;
    chk("R9 blocked request", 32'(dma_req_o), 32'h0);
    chk("R9 raw bit ignores block", 32'(st.data_req), 32'h1);
    blk_i = 1'b0;
    #1;
    chk("R9 unblocked request", 32'(dma_req_o), 32'h1);

    // full, overflow, pointers, concurrent push/pop, underflow
    push_hw(16'hA3A0);
    push_hw(16'hA4A0);
    chk("R10 ready low when full, from local", 32'(st.ready), 32'h0);
    chk("R11 write pointer wraps", 32'(st.iptr), 32'h0);
    push_hw(16'hA5A0);
    chk("R4 push when full ignored", 32'(st.qty), 32'h4);
    chk("R11 write pointer unchanged on refused push", 32'(st.iptr), 32'h0);
    pop_byte();
    chk("R6 entry kept after low byte", 32'(st.qty), 32'h4);
    pop_byte();
    chk("R6 entry removed after high byte", 32'(st.qty), 32'h3);
    chk("R11 read pointer advance", 32'(st.optr), 32'h1);
    pop_byte();
    hw_wr_i = 1'b1;
    hw_wdata_i = 16'hB1B0;
    byte_rd_i = 1'b1;
    expb.push_back(8'hB0);
    expb.push_back(8'hB1);
    tick();
    hw_wr_i = 1'b0;
    byte_rd_i = 1'b0;
    chk("R4 simultaneous push and pop", 32'(st.qty), 32'h3);
    chk("R11 write pointer after concurrent push", 32'(st.iptr), 32'h1);
    for (int i = 0; i < 6; i++) pop_byte();
    chk("R4 drained", 32'(st.qty), 32'h0);
    chk("R6 all bytes delivered", 32'(expb.size()), 32'h0);
    oprev = st.optr;
    pop_byte();
    chk("R4 pop when empty ignored", 32'(st.qty), 32'h0);
    chk("R11 read pointer held on empty pop", 32'(st.optr), 32'(oprev));

    // delayed disable
    push_hw(16'hC1C0);
    push_hw(16'hC2C0);
    dma_busy_i = 1'b1;
    en_i = 1'b0;
    tick();
    chk("R2 enabled held during transfer", 32'(st.enabled), 32'h1);
    chk("R3 no clear while held", 32'(st.qty), 32'h2);
    tick();
    chk("R2 still held", 32'(st.enabled), 32'h1);
    dma_busy_i = 1'b0;
    tick();
    chk("R2 enabled clears after transfer", 32'(st.enabled), 32'h0);
    chk("R3 count cleared", 32'(st.qty), 32'h0);
    chk("R3 pointers cleared", 32'({st.iptr, st.optr}), 32'h0);
    expb.delete();
    en_i = 1'b1;
    tick();
    chk("R2 re-enabled", 32'(st.enabled), 32'h1);

    // byte packing toward local logic
    dir_i = 1'b1;
    flush();
    chk("R10 ready low when empty, to local", 32'(st.ready), 32'h0);
    wr_byte(8'h34);
    chk("R7 single byte flag", 32'({st.hold_full, st.byte_held}), 32'h1);
    wr_byte(8'h12);
    chk("R7 word complete flag", 32'({st.hold_full, st.byte_held}), 32'h2);
    chk("R7 not yet moved", 32'(st.qty), 32'h0);
    tick();
    exph.push_back(16'h1234);
    chk("R7 word moved into FIFO", 32'({st.hold_full, st.byte_held}), 32'h0);
    chk("R4 count after move", 32'(st.qty), 32'h1);
    chk("R10 ready when data present", 32'(st.ready), 32'h1);
    write_entry(16'h5678);
    write_entry(16'h9ABC);
    write_entry(16'hDEF0);
    chk("R4 packed fill", 32'(st.qty), 32'h4);
    wr_byte(8'hAA);
    wr_byte(8'hBB);
    wr_byte(8'hCC);
    chk("R7 byte dropped while word pending", 32'({st.hold_full, st.byte_held}), 32'h2);
    chk("R4 still full", 32'(st.qty), 32'h4);
    pop_hw();
    chk("R4 pop frees entry", 32'(st.qty), 32'h3);
    tick();
    exph.push_back(16'hBBAA);
    chk("R7 pending word moved", 32'(st.qty), 32'h4);
    for (int i = 0; i < 4; i++) pop_hw();
    chk("R5 drained", 32'(st.qty), 32'h0);
    chk("R5 all halfwords delivered", 32'(exph.size()), 32'h0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule